// File: doc/BRIEF.md
# Tag Downlink Command Framer

This block turns one downlink command for a low-frequency read/write tag into a serial bit stream. A command arrives as a flag byte, a 32-bit data word, a 32-bit key (password) and an 8-bit block address. The framer decodes the flags. It then appends the command's fields one per cycle into an internal buffer. Which fields are used, and which preamble and pad bits are added, depends on the command type and on the downlink mode. Every field goes into the buffer MSB first.

When the frame is complete, the framer reports its length in bits. It then hands the frame to a downstream modulator over a valid/ready channel. In three of the four modes the frame goes out one bit per symbol. In the one-of-four mode it goes out as bit pairs. The downlink mode stays visible on an output during the stream, so the modulator can choose its pulse timing. Carrier timing and the tag's reply are not part of this block.

Top module: `dl_framer`

## Requirements
- R1: Flag bits [4:3] select the downlink mode. Value 0 is fixed, 1 is long reference, 2 is leading-zero and 3 is one-of-four. Mode 2 starts the frame with one 0 bit. Mode 3 starts it with two 0 bits. Modes 0 and 1 add no preamble.
- R2: When flag bit 7 (reset) is set, the frame after the preamble is the opcode 00 and nothing else.
- R3: Otherwise the opcode is 1 followed by the page bit (flag bit 1). When test mode (flag bit 2) is set, the opcode is 0 then 1.
- R4: When password mode (flag bit 0) is set, the 32-bit key follows the opcode, MSB first. In modes 2 and 3, two 0 pad bits sit between the opcode and the key.
- R5: Unless regular-read applies, a lock bit of 0 follows. After the data field come the 3 address bits, MSB first. Regular-read is flag bit 5, or the condition in R7. Under regular-read, both the lock bit and the address are left out.
- R6: Unless the read flag (flag bit 6) is set, the 32-bit data word follows the lock bit, MSB first.
- R7: If the read flag is set and the address input is 0xFF, the command is a regular-read. Any other address is reduced to its low 3 bits.
- R8: Once the frame is built, `frame_len` gives its total bit count. It holds that value until the next command is built.
- R9: In mode 3, each symbol carries two bits. The earlier bit is in `sym_bits[1]`. The frame is sent as floor(len/2) pairs. In the other modes, each symbol carries one bit in `sym_bits[0]`, with `sym_bits[1]` = 0.
- R10: If appending a field would take the frame past BUF_BITS, that whole field is dropped. The `overflow` output then goes to 1 and stays there until reset.
- R11: `cmd_ready` is 1 only when the framer is idle, and is 1 after reset. A `cmd_valid` pulse while busy has no effect. The framer returns to idle after the last symbol is accepted.
- R12: While symbols are offered, `sym_mode` equals the downlink mode of the command being sent.
- R13: While `sym_valid` is 1 and `sym_ready` is 0, `sym_valid` and `sym_bits` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Framer idle, command accepted when valid |
| cmd_flags | input | 8 | Command flag byte |
| cmd_data | input | 32 | Data word for write commands |
| cmd_key | input | 32 | Password word |
| cmd_addr | input | 8 | Block address (0xFF selects regular-read on reads) |
| sym_valid | output | 1 | Symbol offered downstream |
| sym_ready | input | 1 | Modulator takes the symbol |
| sym_bits | output | 2 | Symbol: one bit in [0], or a pair with the earlier bit in [1] |
| sym_mode | output | 2 | Downlink mode of the frame being sent |
| frame_len | output | $clog2(BUF_BITS+1) | Bit count of the last built frame |
| overflow | output | 1 | Sticky: a field was dropped for lack of room |

## Verification
The bench builds the framer with BUF_BITS = 72 instead of the default 80. The longest legal frame is 74 bits, so under the default the overflow path can never be reached. With 72 bits, a password write in one-of-four mode loses its address field and leaves an odd 71-bit frame. That frame shows both the dropped-field rule and the floor(len/2) pair count. A password write in leading-zero mode also loses its address. Every shorter frame still fits, so all other field orders are checked whole. The modulator's ready is driven by a pseudo-random sequence, so stalls land at many points in each frame.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 3;
  localparam int FLAG_W    = 8;
  localparam int ADDR_IN_W = 8;
  localparam int FW_W      = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    DL_FIXED   = 2'd0,
    DL_LONGREF = 2'd1,
    DL_LEADZ   = 2'd2,
    DL_QUAD    = 2'd3
  } dlmode_e;

  // order of fields within a frame; behaviour depends on this sequence
  typedef enum logic [3:0] {
    FLD_PRE0 = 4'd0,
    FLD_PRE1 = 4'd1,
    FLD_OPC  = 4'd2,
    FLD_PAD  = 4'd3,
    FLD_KEY  = 4'd4,
    FLD_LOCK = 4'd5,
    FLD_DATA = 4'd6,
    FLD_ADDR = 4'd7
  } field_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BUILD  = 2'd1,
    PH_STREAM = 2'd2
  } phase_e;

  typedef struct packed {
    logic              use_key;
    logic              page;
    logic              test;
    dlmode_e           mode;
    logic              reg_rd;
    logic              rd;
    logic              rst_cmd;
    logic [ADDR_W-1:0] blk;
    logic [WORD_W-1:0] data;
    logic [WORD_W-1:0] key;
  } cmd_t;
endpackage

// File: rtl/dl_flag_decode.sv
module dl_flag_decode
  import dl_pkg::*;
(
  input  logic [FLAG_W-1:0]    flags,
  input  logic [WORD_W-1:0]    data,
  input  logic [WORD_W-1:0]    key,
  input  logic [ADDR_IN_W-1:0] addr,
  output cmd_t                 cmd
);
  logic addr_all_ones;

  assign addr_all_ones = (addr == {ADDR_IN_W{1'b1}});

  always_comb begin
    cmd.use_key = flags[0];
    cmd.page    = flags[1];
    cmd.test    = flags[2];
    cmd.mode    = dlmode_e'(flags[4:3]);
    cmd.rd      = flags[6];
    cmd.reg_rd  = flags[5] | (flags[6] & addr_all_ones);
    cmd.rst_cmd = flags[7];
    cmd.blk     = addr[ADDR_W-1:0];
    cmd.data    = data;
    cmd.key     = key;
  end
endmodule

// File: rtl/dl_frame_builder.sv
module dl_frame_builder
  import dl_pkg::*;
#(
  parameter  int BUF_BITS = 80,
  localparam int LEN_W    = $clog2(BUF_BITS + 1),
  localparam int SUM_W    = LEN_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  cmd_t                cmd,
  output logic                done,
  output logic [BUF_BITS-1:0] bits,
  output logic [LEN_W-1:0]    len,
  output logic                ovf
);
  logic              active;
  field_e            fld;
  logic              inc;
  logic [FW_W-1:0]   w;
  logic [WORD_W-1:0] v;
  logic              fits;
  logic              long_pre;

  assign long_pre = (cmd.mode == DL_LEADZ) || (cmd.mode == DL_QUAD);

  always_comb begin
    inc = 1'b0;
    w   = FW_W'(1);
    v   = '0;
    unique case (fld)
      FLD_PRE0: inc = long_pre;
      FLD_PRE1: inc = (cmd.mode == DL_QUAD);
      FLD_OPC: begin
        inc = 1'b1;
        w   = FW_W'(2);
        if (cmd.rst_cmd)   v = '0;
        else if (cmd.test) v = WORD_W'(2'b01);
        else               v = WORD_W'({1'b1, cmd.page});
      end
      FLD_PAD: begin
        inc = !cmd.rst_cmd && cmd.use_key && long_pre;
        w   = FW_W'(2);
      end
      FLD_KEY: begin
        inc = !cmd.rst_cmd && cmd.use_key;
        w   = FW_W'(WORD_W);
        v   = cmd.key;
      end
      FLD_LOCK: inc = !cmd.rst_cmd && !cmd.reg_rd;
      FLD_DATA: begin
        inc = !cmd.rst_cmd && !cmd.rd;
        w   = FW_W'(WORD_W);
        v   = cmd.data;
      end
      FLD_ADDR: begin
        inc = !cmd.rst_cmd && !cmd.reg_rd;
        w   = FW_W'(ADDR_W);
        v   = WORD_W'(cmd.blk);
      end
      default: inc = 1'b0;
    endcase
  end

  assign fits = (SUM_W'(len) + SUM_W'(w)) <= SUM_W'(BUF_BITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      fld    <= FLD_PRE0;
      done   <= 1'b0;
      bits   <= '0;
      len    <= '0;
      ovf    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        fld    <= FLD_PRE0;
        bits   <= '0;
        len    <= '0;
      end else if (active) begin
        if (inc) begin
          if (fits) begin
            bits <= (bits << w) | BUF_BITS'(v);
            len  <= len + LEN_W'(w);
          end else begin
            ovf <= 1'b1;
          end
        end
        if (fld == FLD_ADDR) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          fld <= field_e'(fld + 4'd1);
        end
      end
    end
  end

  // R8
  len_cap_chk: assert property (@(posedge clk) disable iff (rst)
    len <= LEN_W'(BUF_BITS));

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (len == '0));
endmodule

// File: rtl/dl_bit_streamer.sv
module dl_bit_streamer
  import dl_pkg::*;
#(
  parameter int BUF_BITS = 80,
  parameter int LEN_W    = $clog2(BUF_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                pair_in,
  input  logic [LEN_W-1:0]    len,
  input  logic [BUF_BITS-1:0] bits,
  output logic                sym_valid,
  input  logic                sym_ready,
  output logic [1:0]          sym_bits,
  output logic                fin
);
  logic             active;
  logic             pair;
  logic [LEN_W-1:0] ptr;
  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] lo_idx;
  logic [LEN_W-1:0] rem_init;

  assign rem_init  = pair_in ? (len >> 1) : len;
  assign lo_idx    = (ptr == '0) ? '0 : ptr - LEN_W'(1);
  assign sym_valid = active;
  assign sym_bits  = pair ? {bits[ptr], bits[lo_idx]} : {1'b0, bits[ptr]};

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pair   <= 1'b0;
      ptr    <= '0;
      rem    <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        pair   <= pair_in;
        ptr    <= len - LEN_W'(1);
        rem    <= rem_init;
        active <= (rem_init != '0);
        fin    <= (rem_init == '0);
      end else if (active && sym_ready) begin
        ptr <= ptr - (pair ? LEN_W'(2) : LEN_W'(1));
        rem <= rem - LEN_W'(1);
        if (rem == LEN_W'(1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_bits)));
endmodule

// File: rtl/dl_framer.sv
module dl_framer
  import dl_pkg::*;
#(
  parameter  int BUF_BITS = 80,
  localparam int LEN_W    = $clog2(BUF_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [FLAG_W-1:0]    cmd_flags,
  input  logic [WORD_W-1:0]    cmd_data,
  input  logic [WORD_W-1:0]    cmd_key,
  input  logic [ADDR_IN_W-1:0] cmd_addr,
  output logic                 sym_valid,
  input  logic                 sym_ready,
  output logic [1:0]           sym_bits,
  output logic [1:0]           sym_mode,
  output logic [LEN_W-1:0]     frame_len,
  output logic                 overflow
);
  cmd_t                dec;
  cmd_t                lat;
  phase_e              phase;
  logic                accept;
  logic                build_go;
  logic                build_done;
  logic                stream_fin;
  logic [BUF_BITS-1:0] frame_bits;

  dl_flag_decode u_dec (
    .flags (cmd_flags),
    .data  (cmd_data),
    .key   (cmd_key),
    .addr  (cmd_addr),
    .cmd   (dec)
  );

  assign cmd_ready = (phase == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign sym_mode  = lat.mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      lat      <= '0;
      build_go <= 1'b0;
    end else begin
      build_go <= accept;
      unique case (phase)
        PH_IDLE: if (accept) begin
          lat   <= dec;
          phase <= PH_BUILD;
        end
        PH_BUILD:  if (build_done) phase <= PH_STREAM;
        PH_STREAM: if (stream_fin) phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  dl_frame_builder #(.BUF_BITS(BUF_BITS)) u_build (
    .clk   (clk),
    .rst   (rst),
    .start (build_go),
    .cmd   (lat),
    .done  (build_done),
    .bits  (frame_bits),
    .len   (frame_len),
    .ovf   (overflow)
  );

  dl_bit_streamer #(.BUF_BITS(BUF_BITS), .LEN_W(LEN_W)) u_stream (
    .clk       (clk),
    .rst       (rst),
    .start     (build_done),
    .pair_in   (lat.mode == DL_QUAD),
    .len       (frame_len),
    .bits      (frame_bits),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .sym_bits  (sym_bits),
    .fin       (stream_fin)
  );

  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !sym_valid);

  // R9
  single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_mode != 2'd3) |-> (sym_bits[1] == 1'b0));

  // R12
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> (!sym_valid || $stable(sym_mode)));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

// File: tb/test_dl_framer.sv
module test_dl_framer;
  localparam int BUF = 72;
  localparam int LW  = $clog2(BUF + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [7:0]    cmd_flags = '0;
  logic [31:0]   cmd_data = '0;
  logic [31:0]   cmd_key = '0;
  logic [7:0]    cmd_addr = '0;
  logic          sym_valid;
  logic          sym_ready;
  logic [1:0]    sym_bits;
  logic [1:0]    sym_mode;
  logic [LW-1:0] frame_len;
  logic          overflow;

  int         n_chk = 0;
  int         n_fail = 0;
  logic [1:0] exp_q[$];
  int         exp_len = 0;
  bit         exp_ovf = 1'b0;
  logic [1:0] exp_mode = 2'd0;
  string      cur_req = "R1";
  bit         eb[0:127];
  int         nb;
  logic [7:0] lf;
  bit         stall_pend = 1'b0;
  logic [1:0] stall_bits = '0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  dl_framer #(.BUF_BITS(BUF)) i_dl_framer (
    .clk, .rst, .cmd_valid, .cmd_ready, .cmd_flags, .cmd_data, .cmd_key,
    .cmd_addr, .sym_valid, .sym_ready, .sym_bits, .sym_mode, .frame_len,
    .overflow
  );

  always @(posedge clk) begin
    if (rst) begin
      lf        <= 8'h5A;
      sym_ready <= 1'b0;
    end else begin
      lf        <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      sym_ready <= lf[0] | lf[2];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_pend) begin
        check(sym_valid, "R13", "valid dropped during stall", sym_valid, 1);
        check(sym_bits == stall_bits, "R13", "bits changed during stall", sym_bits, stall_bits);
      end
      if (sym_valid && sym_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "symbol with empty scoreboard", sym_bits, 0);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          check(sym_bits == e, cur_req, "symbol", sym_bits, e);
          check(sym_mode == exp_mode, "R12", "sym_mode", sym_mode, exp_mode);
        end
      end
      stall_pend = sym_valid && !sym_ready;
      stall_bits = sym_bits;
    end
  end

  task automatic push_field(input int w, input logic [31:0] v);
    if (nb + w > BUF) exp_ovf = 1'b1;
    else for (int k = w - 1; k >= 0; k--) begin
      eb[nb] = v[k];
      nb++;
    end
  endtask

  task automatic run_cmd(input logic [7:0] f, input logic [31:0] d,
                         input logic [31:0] k, input logic [7:0] a,
                         input string req);
    logic [1:0] md;
    bit rd, regrd;
    md    = f[4:3];
    rd    = f[6];
    regrd = f[5] | (rd && a == 8'hFF);
    nb    = 0;
    // R1 preamble
    if (md >= 2) push_field(1, 0);
    if (md == 3) push_field(1, 0);
    if (f[7]) push_field(2, 0);              // R2
    else begin
      push_field(2, f[2] ? 32'd1 : {30'd0, 1'b1, f[1]});   // R3
      if (f[0]) begin                        // R4
        if (md >= 2) push_field(2, 0);
        push_field(32, k);
      end
      if (!regrd) push_field(1, 0);          // R5 lock
      if (!rd) push_field(32, d);            // R6
      if (!regrd) push_field(3, {29'd0, a[2:0]});   // R5, R7
    end
    // R9 symbol packing
    if (md == 3) for (int i = 0; i + 1 < nb; i += 2) exp_q.push_back({eb[i], eb[i+1]});
    else for (int i = 0; i < nb; i++) exp_q.push_back({1'b0, eb[i]});
    exp_len  = nb;
    exp_mode = md;
    cur_req  = req;

    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_flags = f; cmd_data = d; cmd_key = k; cmd_addr = a;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    // R11: a command offered while busy must change nothing
    cmd_flags = 8'h98; cmd_data = 32'hFFFF_FFFF; cmd_key = 32'hFFFF_FFFF; cmd_addr = 8'h07;
    @(negedge clk);
    cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    check(exp_q.size() == 0, "R11", "symbols left after idle", exp_q.size(), 0);
    check(frame_len == LW'(exp_len), "R8", "frame_len", frame_len, exp_len);
    check(overflow == exp_ovf, "R10", "overflow flag", overflow, exp_ovf);
    exp_q.delete();
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "R11", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R11", "ready after reset", cmd_ready, 1);
    check(sym_valid == 1'b0, "R11", "valid after reset", sym_valid, 0);
    check(overflow == 1'b0, "R10", "overflow after reset", overflow, 0);
    check(frame_len == '0, "R8", "frame_len after reset", frame_len, 0);

    run_cmd(8'h00, 32'hA5A5_0F0F, 32'h0, 8'h05, "R3/R5/R6");         // fixed write page 0
    run_cmd(8'h03, 32'h1234_5678, 32'hC001_D00D, 8'h02, "R3/R4/R6"); // key, page 1
    run_cmd(8'h04, 32'h8000_0001, 32'h0, 8'h07, "R3");               // test opcode
    run_cmd(8'h48, 32'hDEAD_BEEF, 32'h0, 8'h03, "R5/R6/R12");        // long-ref read
    run_cmd(8'h10, 32'hF0F0_1234, 32'h0, 8'h06, "R1/R9");            // leading-zero write
    run_cmd(8'h51, 32'h0, 32'h89AB_CDEF, 8'hFF, "R1/R4/R7");         // LZ regular-read
    run_cmd(8'h18, 32'h0F1E_2D3C, 32'h0, 8'h04, "R1/R9");            // one-of-four write
    run_cmd(8'h59, 32'h0, 32'h7654_3210, 8'h02, "R4/R9");            // Q4 keyed read
    run_cmd(8'h98, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h07, "R2/R9");    // reset, Q4
    run_cmd(8'h80, 32'hFFFF_FFFF, 32'h0, 8'h05, "R2");               // reset, fixed
    run_cmd(8'h61, 32'h0, 32'h5555_AAAA, 8'h00, "R4/R7");            // wake-up
    run_cmd(8'h40, 32'h0, 32'h0, 8'h0D, "R7");                       // address masked to 5
    run_cmd(8'h58, 32'h0, 32'h0, 8'hFF, "R7/R9");                    // Q4 regular read
    run_cmd(8'h11, 32'h1357_9BDF, 32'h2468_ACE0, 8'h03, "R10");      // LZ keyed write, overflow
    run_cmd(8'h19, 32'hCAFE_F00D, 32'hBEEF_0123, 8'h05, "R10/R9");   // Q4 odd length
    run_cmd(8'h40, 32'h0, 32'h0, 8'h01, "R10");                      // sticky flag
    summary();
  end
endmodule